// File: doc/BRIEF.md
# Selectable Zero-Substitution Line Codec (B3ZS / HDB3)

This block converts between single-rail NRZ data on the framer side and dual-rail bipolar logic signals on the line side. A marked bit becomes a pulse on one rail. Successive marks alternate between the positive and negative rails. A select input chooses the substitution rule. For the three DS3/STS-1 type rates, every run of three zeros is replaced using B3ZS. For the E3 rate, every run of four zeros is replaced using HDB3. In both cases the replacement contains a deliberate bipolar violation, so that the line never goes quiet for long.

In the receive direction the block finds these violations. It removes the substitution pulses and restores the original zeros. It also raises a one-cycle flag for any violation that does not fit a legal substitution pattern. An active-low enable selects codec mode. When the enable is high, both directions pass raw dual-rail signals through unchanged, and a transmit input with both rails high is flagged. A signal-present input, active high, blanks the receive data outputs when it drops.

Both directions move one bit per clock. Each has a fixed latency that depends on the selected rule. The rule and the mode are expected to change only together with a reset.

Top module: `zsub_codec`

## Requirements
- R1: A synchronous active-high reset drives every output low. The first pulse sent after reset in codec mode is positive (ln_out_pos=1, ln_out_neg=0).
- R2: With codec_en_n=0 and e3_sel=0, each data 1 is sent as a pulse of the polarity opposite to the previous pulse. Each run of three zeros is sent as 0,0,V when an odd number of pulses has gone out since the last V, and as B,0,V when that number is even. V repeats the previous pulse polarity. B alternates normally. A bit sampled at one clock edge appears on the line outputs 3 edges later.
- R3: With codec_en_n=0 and e3_sel=1, the same rule applies to runs of four zeros, sent as 0,0,0,V (odd count) or B,0,0,V (even count). The latency is 4 edges.
- R4: Once the first pulse has gone out in codec mode, the line outputs never show more than 2 (B3ZS) or 3 (HDB3) zero symbols in a row. They never have both rails high.
- R5: In codec mode, tx_in_neg has no effect on the line outputs, and tx_clash stays low.
- R6: In codec mode, a received substitution (a same-polarity pulse preceded by the zeros of a legal pattern) is decoded back to zeros, together with its B pulse. Every other pulse decodes to 1. Decoded data appears on rx_out_pos 3 (B3ZS) or 4 (HDB3) edges after sampling. rx_out_neg stays low.
- R7: In codec mode, a violation that does not fit a legal pattern is decoded as 1 and raises rx_viol for one cycle, right after the edge that sampled it. A legal B3ZS pattern needs a zero just before V. A legal HDB3 pattern needs two zeros just before V. Samples with both rails high are also illegal. rx_viol never rises in bypass mode.
- R8: With codec_en_n=1, ln_out_pos/neg repeat tx_in_pos/neg, and rx_out_pos/neg repeat ln_in_pos/neg, each one edge after sampling.
- R9: In bypass mode, tx_clash is high for the cycle after any edge that sampled tx_in_pos and tx_in_neg both high.
- R10: After any edge that samples sig_ok low, rx_out_pos and rx_out_neg are low for that cycle, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock for both directions |
| rst | input | 1 | Synchronous reset, active high |
| codec_en_n | input | 1 | 0 = codec mode, 1 = raw dual-rail bypass |
| e3_sel | input | 1 | 0 = three-zero rule (B3ZS), 1 = four-zero rule (HDB3) |
| tx_in_pos | input | 1 | NRZ data in codec mode; positive rail in bypass |
| tx_in_neg | input | 1 | Negative rail in bypass; ignored in codec mode |
| ln_out_pos | output | 1 | Line positive-pulse rail |
| ln_out_neg | output | 1 | Line negative-pulse rail |
| tx_clash | output | 1 | Both transmit rails were high in bypass mode |
| ln_in_pos | input | 1 | Received positive-pulse rail |
| ln_in_neg | input | 1 | Received negative-pulse rail |
| sig_ok | input | 1 | Received signal present; low blanks the receive rails |
| rx_out_pos | output | 1 | Decoded NRZ data in codec mode; positive rail in bypass |
| rx_out_neg | output | 1 | Low in codec mode; negative rail in bypass |
| rx_viol | output | 1 | One-cycle flag for an illegal received violation |

## Verification
The hardest situations to reach are the two parity branches of the substitution. Which pattern is sent depends on how many pulses have gone out since the last violation, and a violation can be decided while earlier pulses are still inside the look-ahead pipeline. The bench drives long zero-heavy pseudo-random streams and fixed sequences that start from reset with zeros. It compares the line outputs with its own batch encoder, which works through the whole stream in one pass. It then feeds that encoder's rails back into the receive side, checks that the original bits return, and adds hand-built illegal violations for each rule.

// File: rtl/zs_pkg.sv
package zs_pkg;

  // Longest zero run replaced by a substitution (four-zero rule)
  localparam int ZS_DEPTH = 4;
  // Width of the zero-run counters
  localparam int ZS_CW = $clog2(ZS_DEPTH + 1);

  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_ALT  = 2'd1,   // pulse that alternates polarity (data mark or B)
    SYM_VIOL = 2'd2    // pulse that repeats polarity (V)
  } zs_sym_e;

  // Number of zeros that one substitution replaces
  function automatic int zs_run_len(input logic e3);
    return e3 ? 4 : 3;
  endfunction

  // An alternating B pulse is needed when the pulse count since the last V is even
  function automatic logic zs_need_b(input logic odd_count);
    return !odd_count;
  endfunction

  // Polarity of an output pulse: 1 = positive
  function automatic logic zs_pulse_pos(input zs_sym_e s, input logic last_pos);
    return (s == SYM_VIOL) ? last_pos : !last_pos;
  endfunction

  // Legal substitution: the run-2 most recent raw samples before V hold no pulse
  function automatic logic zs_window_clear(input logic [ZS_DEPTH-1:0] raw, input int run);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < ZS_DEPTH; i++)
      if (i < run - 2 && raw[i]) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/zs_encoder.sv
module zs_encoder
  import zs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic codec_en_n,
  input  logic e3_sel,
  input  logic tx_a,
  input  logic tx_b,
  output logic line_p,
  output logic line_n,
  output logic clash
);

  zs_sym_e          pipe [ZS_DEPTH];
  logic [ZS_CW-1:0] zcnt;
  logic             odd_count;
  logic             last_pos;
  int               run_len;
  zs_sym_e          tap;

  // named internal events
  logic sub_fire;
  logic sub_with_b;
  logic tap_pulse;
  logic tap_pos;

  assign run_len    = zs_run_len(e3_sel);
  assign sub_fire   = !tx_a && (int'(zcnt) == run_len - 1);
  assign sub_with_b = sub_fire && zs_need_b(odd_count);

  always_comb begin
    tap = SYM_ZERO;
    for (int i = 0; i < ZS_DEPTH; i++)
      if (i == run_len - 1) tap = pipe[i];
  end

  assign tap_pulse = (tap != SYM_ZERO);
  assign tap_pos   = zs_pulse_pos(tap, last_pos);

  // look-ahead symbol pipeline, newest at index 0
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ZS_DEPTH; i++) pipe[i] <= SYM_ZERO;
      zcnt      <= '0;
      odd_count <= 1'b0;
    end else begin
      pipe[0] <= sub_fire ? SYM_VIOL : (tx_a ? SYM_ALT : SYM_ZERO);
      for (int i = 1; i < ZS_DEPTH; i++)
        pipe[i] <= (sub_with_b && i == run_len - 1) ? SYM_ALT : pipe[i-1];
      if (tx_a || sub_fire) zcnt <= '0;
      else                  zcnt <= zcnt + 1'b1;
      if (sub_fire)  odd_count <= 1'b0;
      else if (tx_a) odd_count <= !odd_count;
    end
  end

  // line output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      line_p   <= 1'b0;
      line_n   <= 1'b0;
      clash    <= 1'b0;
      last_pos <= 1'b0;
    end else if (codec_en_n) begin
      line_p <= tx_a;
      line_n <= tx_b;
      clash  <= tx_a && tx_b;
    end else begin
      line_p <= tap_pulse && tap_pos;
      line_n <= tap_pulse && !tap_pos;
      clash  <= 1'b0;
      if (tap_pulse) last_pos <= tap_pos;
    end
  end

  // checker state: zero run seen on the line outputs
  logic [2:0] chk_zrun;
  logic       chk_armed;
  always_ff @(posedge clk) begin
    if (rst || codec_en_n) begin
      chk_zrun  <= '0;
      chk_armed <= 1'b0;
    end else if (line_p || line_n) begin
      chk_zrun  <= '0;
      chk_armed <= 1'b1;
    end else if (chk_armed && chk_zrun != 3'd7) begin
      chk_zrun <= chk_zrun + 3'd1;
    end
  end

  assert_zero_run_R4: assert property (@(posedge clk) disable iff (rst)
    chk_armed |-> (int'(chk_zrun) < run_len));

  assert_rails_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    $past(!codec_en_n) |-> !(line_p && line_n));

  assert_clash_source_R9: assert property (@(posedge clk) disable iff (rst)
    clash |-> $past(codec_en_n && tx_a && tx_b));

  assert_clash_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    $past(!codec_en_n) |-> !clash);

endmodule

// File: rtl/zs_decoder.sv
module zs_decoder
  import zs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic codec_en_n,
  input  logic e3_sel,
  input  logic rx_a,
  input  logic rx_b,
  input  logic sig_ok,
  output logic data_p,
  output logic data_n,
  output logic viol
);

  logic [ZS_DEPTH-1:0] dly;   // decoded bits, newest at index 0
  logic [ZS_DEPTH-1:0] raw;   // raw pulse presence, newest at index 0
  logic                last_pos;
  logic                armed;
  int                  run_len;
  logic                tap;

  // named internal events
  logic single_pulse;
  logic both_rails;
  logic same_pol;
  logic good_sub;
  logic bad_sub;

  assign run_len      = zs_run_len(e3_sel);
  assign single_pulse = rx_a ^ rx_b;
  assign both_rails   = rx_a && rx_b;
  assign same_pol     = armed && single_pulse && (rx_a == last_pos);
  assign good_sub     = same_pol && zs_window_clear(raw, run_len);
  assign bad_sub      = (same_pol && !good_sub) || both_rails;

  always_comb begin
    tap = 1'b0;
    for (int i = 0; i < ZS_DEPTH; i++)
      if (i == run_len - 1) tap = dly[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dly      <= '0;
      raw      <= '0;
      last_pos <= 1'b0;
      armed    <= 1'b0;
    end else begin
      dly[0] <= good_sub ? 1'b0 : (rx_a || rx_b);
      raw[0] <= rx_a || rx_b;
      for (int i = 1; i < ZS_DEPTH; i++) begin
        dly[i] <= (good_sub && i == run_len - 1) ? 1'b0 : dly[i-1];
        raw[i] <= raw[i-1];
      end
      if (single_pulse) begin
        last_pos <= rx_a;
        armed    <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_p <= 1'b0;
      data_n <= 1'b0;
      viol   <= 1'b0;
    end else begin
      viol <= !codec_en_n && bad_sub;
      if (!sig_ok) begin
        data_p <= 1'b0;
        data_n <= 1'b0;
      end else if (codec_en_n) begin
        data_p <= rx_a;
        data_n <= rx_b;
      end else begin
        data_p <= tap;
        data_n <= 1'b0;
      end
    end
  end

  assert_los_blank_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(sig_ok) |-> (!data_p && !data_n));

  assert_neg_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    $past(!codec_en_n) |-> !data_n);

  assert_viol_codec_only_R7: assert property (@(posedge clk) disable iff (rst)
    viol |-> $past(!codec_en_n));

endmodule

// File: rtl/zsub_codec.sv
module zsub_codec (
  input  logic clk,
  input  logic rst,
  input  logic codec_en_n,
  input  logic e3_sel,
  input  logic tx_in_pos,
  input  logic tx_in_neg,
  output logic ln_out_pos,
  output logic ln_out_neg,
  output logic tx_clash,
  input  logic ln_in_pos,
  input  logic ln_in_neg,
  input  logic sig_ok,
  output logic rx_out_pos,
  output logic rx_out_neg,
  output logic rx_viol
);

  zs_encoder u_enc (
    .clk        (clk),
    .rst        (rst),
    .codec_en_n (codec_en_n),
    .e3_sel     (e3_sel),
    .tx_a       (tx_in_pos),
    .tx_b       (tx_in_neg),
    .line_p     (ln_out_pos),
    .line_n     (ln_out_neg),
    .clash      (tx_clash)
  );

  zs_decoder u_dec (
    .clk        (clk),
    .rst        (rst),
    .codec_en_n (codec_en_n),
    .e3_sel     (e3_sel),
    .rx_a       (ln_in_pos),
    .rx_b       (ln_in_neg),
    .sig_ok     (sig_ok),
    .data_p     (rx_out_pos),
    .data_n     (rx_out_neg),
    .viol       (rx_viol)
  );

endmodule

// File: tb/sim_zsub_codec.sv
module sim_zsub_codec;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic codec_en_n = 1'b0, e3_sel = 1'b0;
  logic tx_in_pos = 1'b0, tx_in_neg = 1'b0;
  logic ln_in_pos = 1'b0, ln_in_neg = 1'b0, sig_ok = 1'b1;
  logic ln_out_pos, ln_out_neg, tx_clash, rx_out_pos, rx_out_neg, rx_viol;

  always #5 clk = ~clk;

  zsub_codec u0 (.*);

  int vectors = 0;
  int misses  = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic stim  [0:127];
  logic ep    [0:127];
  logic en    [0:127];
  logic exp_d [0:127];
  logic exp_v [0:127];
  int   len;

  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input logic got, input logic exp, input string tag);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s got=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic do_reset(input logic byp, input logic e3);
    @(negedge clk);
    rst = 1'b1; codec_en_n = byp; e3_sel = e3;
    tx_in_pos = 1'b0; tx_in_neg = 1'b0; ln_in_pos = 1'b0; ln_in_neg = 1'b0; sig_ok = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // batch reference: greedy scan of the whole stream
  task automatic model(input int run);
    logic last, odd;
    int i;
    last = 1'b0; odd = 1'b0; i = 0;
    for (int k = 0; k < 128; k++) begin ep[k] = 1'b0; en[k] = 1'b0; end
    while (i < len) begin
      logic zr;
      zr = (i + run <= len);
      for (int k = 0; k < run; k++) if (zr && stim[i+k]) zr = 1'b0;
      if (zr) begin
        if (!odd) begin
          last = !last; ep[i] = last; en[i] = !last;
        end
        ep[i+run-1] = last; en[i+run-1] = !last;
        odd = 1'b0; i += run;
      end else begin
        if (stim[i]) begin
          last = !last; ep[i] = last; en[i] = !last; odd = !odd;
        end
        i++;
      end
    end
  endtask

  task automatic run_encode(input logic e3, input string tag);
    int n, zr;
    logic seen;
    n = e3 ? 4 : 3; zr = 0; seen = 1'b0;
    model(n);
    do_reset(1'b0, e3);
    for (int m = 0; m <= len + n + 1; m++) begin
      int j;
      if (m > 0) @(negedge clk);
      j = m - n - 1;
      if (j >= 0 && j <= len - n) begin
        chk(ln_out_pos, ep[j], {tag, " pos rail"});
        chk(ln_out_neg, en[j], {tag, " neg rail"});
        if (ln_out_pos || ln_out_neg) begin zr = 0; seen = 1'b1; end
        else if (seen) zr++;
        chk(zr < n, 1'b1, "R4 zero run limit");
      end
      if (m > 0) chk(tx_clash, 1'b0, "R5 clash quiet in codec mode");
      lfsr = step(lfsr);
      tx_in_pos = (m < len) ? stim[m] : 1'b0;
      tx_in_neg = lfsr[0];   // R5: must be ignored
    end
  endtask

  // drive ep/en into the receiver; expect exp_d / exp_v; sig_ok low for m in [lo_a, lo_b]
  task automatic run_rails(input logic e3, input int lo_a, input int lo_b, input string tag);
    int n;
    n = e3 ? 4 : 3;
    do_reset(1'b0, e3);
    for (int m = 0; m <= len + n + 1; m++) begin
      int j;
      if (m > 0) @(negedge clk);
      j = m - n - 1;
      if (m > 0 && m - 1 >= lo_a && m - 1 <= lo_b) begin
        chk(rx_out_pos, 1'b0, "R10 blank pos");
        chk(rx_out_neg, 1'b0, "R10 blank neg");
      end else if (j >= 0 && j <= len - n) begin
        chk(rx_out_pos, exp_d[j], {tag, " data"});
        chk(rx_out_neg, 1'b0, "R6 neg output low");
      end
      if (m > 0 && m - 1 < len) chk(rx_viol, exp_v[m-1], {tag, " viol flag"});
      ln_in_pos = (m < len) ? ep[m] : 1'b0;
      ln_in_neg = (m < len) ? en[m] : 1'b0;
      sig_ok    = !(m >= lo_a && m <= lo_b);
    end
  endtask

  task automatic clear_stim;
    for (int k = 0; k < 128; k++) begin
      stim[k] = 1'b0; ep[k] = 1'b0; en[k] = 1'b0; exp_d[k] = 1'b0; exp_v[k] = 1'b0;
    end
  endtask

  task automatic fill_random(input int n, input int dens);
    clear_stim();
    len = n;
    for (int k = 0; k < n; k++) begin
      lfsr = step(lfsr);
      stim[k] = (int'(lfsr[2:0]) < dens);
    end
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    rst = 1'b1; codec_en_n = 1'b1;
    tx_in_pos = 1'b1; tx_in_neg = 1'b1; ln_in_pos = 1'b1; ln_in_neg = 1'b1; sig_ok = 1'b1;
    repeat (2) @(negedge clk);
    chk(ln_out_pos, 1'b0, "R1 reset ln_out_pos");
    chk(ln_out_neg, 1'b0, "R1 reset ln_out_neg");
    chk(tx_clash,   1'b0, "R1 reset tx_clash");
    chk(rx_out_pos, 1'b0, "R1 reset rx_out_pos");
    chk(rx_out_neg, 1'b0, "R1 reset rx_out_neg");
    chk(rx_viol,    1'b0, "R1 reset rx_viol");
  endtask

  task automatic t_encode_directed;
    // leading zeros right after reset: even count, B then V, first pulse positive
    clear_stim(); len = 12;
    stim[4] = 1'b1;
    run_encode(1'b0, "R1 R2 leading zeros B3ZS");
    if (ep[0] !== 1'b1) begin misses++; $display("FAIL R1 model first pulse got=%0b expected=1", ep[0]); end
    clear_stim(); len = 14;
    stim[0] = 1'b1; stim[5] = 1'b1; stim[6] = 1'b1;
    run_encode(1'b0, "R2 odd then even B3ZS");
    clear_stim(); len = 14;
    stim[3] = 1'b1; stim[9] = 1'b1;
    run_encode(1'b1, "R1 R3 leading zeros HDB3");
    clear_stim(); len = 16;
    stim[0] = 1'b1; stim[5] = 1'b1; stim[6] = 1'b1; stim[11] = 1'b1;
    run_encode(1'b1, "R3 odd then even HDB3");
  endtask

  task automatic t_encode_random;
    fill_random(96, 2); run_encode(1'b0, "R2 random sparse B3ZS");
    fill_random(96, 4); run_encode(1'b0, "R2 random dense B3ZS");
    fill_random(96, 2); run_encode(1'b1, "R3 random sparse HDB3");
    fill_random(96, 5); run_encode(1'b1, "R3 random dense HDB3");
  endtask

  task automatic t_decode_loop;
    for (int r = 0; r < 2; r++) begin
      fill_random(96, 2);
      model(r == 1 ? 4 : 3);
      for (int k = 0; k < 128; k++) exp_d[k] = stim[k];
      run_rails(r == 1, 1000, 1000, "R6 loop decode");
    end
  endtask

  task automatic t_decode_illegal;
    // B3ZS: +,+ back to back is not a legal pattern
    clear_stim(); len = 10;
    ep[0] = 1'b1; ep[1] = 1'b1;
    exp_d[0] = 1'b1; exp_d[1] = 1'b1; exp_v[1] = 1'b1;
    run_rails(1'b0, 1000, 1000, "R7 B3ZS adjacent same polarity");
    // HDB3: +,0,+ lacks the second zero
    clear_stim(); len = 10;
    ep[0] = 1'b1; ep[2] = 1'b1;
    exp_d[0] = 1'b1; exp_d[2] = 1'b1; exp_v[2] = 1'b1;
    run_rails(1'b1, 1000, 1000, "R7 HDB3 short window");
    // HDB3: +,0,0,+ is a legal B00V, decodes to zeros
    clear_stim(); len = 10;
    ep[0] = 1'b1; ep[3] = 1'b1; en[5] = 1'b1;
    exp_d[5] = 1'b1;
    run_rails(1'b1, 1000, 1000, "R6 HDB3 legal B00V");
    // both rails high is illegal
    clear_stim(); len = 10;
    ep[2] = 1'b1; en[2] = 1'b1; exp_d[2] = 1'b1; exp_v[2] = 1'b1;
    run_rails(1'b0, 1000, 1000, "R7 both rails high");
  endtask

  task automatic t_los_codec;
    clear_stim(); len = 40;
    for (int k = 0; k < 40; k++) begin stim[k] = 1'b1; exp_d[k] = 1'b1; end
    model(3);
    run_rails(1'b0, 12, 19, "R10 codec stream");
  endtask

  task automatic t_bypass;
    logic pa, pb, ra, rb, ok;
    do_reset(1'b1, 1'b0);
    pa = 0; pb = 0; ra = 0; rb = 0; ok = 1;
    for (int m = 0; m < 60; m++) begin
      if (m > 0) begin
        @(negedge clk);
        chk(ln_out_pos, pa, "R8 bypass tx pos");
        chk(ln_out_neg, pb, "R8 bypass tx neg");
        chk(tx_clash, pa & pb, "R9 bypass clash");
        chk(rx_out_pos, ok & ra, "R8 R10 bypass rx pos");
        chk(rx_out_neg, ok & rb, "R8 R10 bypass rx neg");
        chk(rx_viol, 1'b0, "R7 no viol in bypass");
      end
      lfsr = step(lfsr);
      pa = lfsr[0]; pb = lfsr[1]; ra = lfsr[2]; rb = lfsr[3];
      ok = !(m >= 30 && m < 36);
      tx_in_pos = pa; tx_in_neg = pb; ln_in_pos = ra; ln_in_neg = rb; sig_ok = ok;
    end
  endtask

  initial begin
    t_reset_state();
    t_encode_directed();
    t_encode_random();
    t_decode_loop();
    t_decode_illegal();
    t_los_codec();
    t_bypass();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired got=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule